// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the register-transfer datapath of a small load/store processor that runs each instruction over several clock cycles. It contains the program counter, the instruction register, a memory data register, two operand latches, an ALU result latch, an 8-entry register file and an ALU. It also contains the multiplexers that steer values between them. Every choice is made by control inputs that an external sequencer drives. The datapath returns the current opcode and the ALU zero flag to that sequencer.

Instructions and data share one memory port. Each cycle, a control input picks the memory address: either the program counter or the ALU result latch. Every intermediate value is held in a named register from one cycle to the next. This lets the sequencer build fetch, decode, execute, memory and write-back steps out of plain control vectors.

Instruction layout (16 bits): opcode in bits 15:12, rs in 11:9, rt in 8:6, rd in 5:3, a signed 6-bit immediate in 5:0, and a 12-bit jump target in 11:0.

Top module: `mdp_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0. With address select 0, the first address presented afterwards is 0.
- R2: With address select 0, `mem_addr` shows the program counter. When `ctl_pc_load` is high and `ctl_pc_src` is 0, the PC takes the live ALU result. With the PC as operand A, constant 4 as operand B and operation add, this advances the PC by 4.
- R3: The instruction register loads `mem_rdata` only on a rising edge where `ctl_ir_load` is high. `opcode` always shows instruction-register bits 15:12.
- R4: `ctl_alu_op` selects the ALU operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). The result is latched into the ALU result register on every edge.
- R5: `zero` is high exactly when the current ALU result is all zeros.
- R6: With address select 1, `mem_addr` shows the ALU result latch. A load adds rs to the sign-extended 6-bit immediate, latches the memory word into the memory data register, and writes it to register rt when `ctl_rf_dst`=0 and `ctl_rf_from_mem`=1.
- R7: `mem_wdata` always shows operand latch B, which is loaded from register rt on every edge. `mem_wr` and `mem_rd` follow their control inputs.
- R8: When `ctl_rf_we`=1, `ctl_rf_dst`=1 and `ctl_rf_from_mem`=0, register rd is written from the ALU result latch.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: With `ctl_pc_cond`=1 and `ctl_pc_src`=1, the PC loads the ALU result latch only if `zero` is high. Otherwise the PC is unchanged.
- R11: With `ctl_pc_src`=2 and `ctl_pc_load`=1, the PC becomes {PC[15:14], target[11:0], 2'b00}.
- R12: `ctl_srca` picks operand A: 0 for the PC, 1 for latch A (rs). `ctl_srcb` picks operand B: 0 for latch B, 1 for constant 4, 2 for the sign-extended immediate, 3 for the sign-extended immediate shifted left by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Shared memory address |
| mem_wdata | output | 16 | Store data (operand latch B) |
| mem_rdata | input | 16 | Memory read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ctl_mem_rd | input | 1 | Request memory read |
| ctl_mem_wr | input | 1 | Request memory write |
| ctl_addr_sel | input | 1 | 0: PC, 1: ALU result latch as address |
| ctl_ir_load | input | 1 | Load instruction register |
| ctl_pc_load | input | 1 | Unconditional PC load |
| ctl_pc_cond | input | 1 | PC load when zero is high |
| ctl_pc_src | input | 2 | Next PC: 0 ALU, 1 result latch, 2 jump |
| ctl_srca | input | 1 | ALU operand A select |
| ctl_srcb | input | 2 | ALU operand B select |
| ctl_alu_op | input | 3 | ALU operation |
| ctl_rf_we | input | 1 | Register file write enable |
| ctl_rf_dst | input | 1 | Write index: 0 rt, 1 rd |
| ctl_rf_from_mem | input | 1 | Write data: 0 result latch, 1 memory data register |
| opcode | output | 4 | Instruction opcode to the sequencer |
| zero | output | 1 | ALU zero flag |

## Verification
Some rules are checked by assertions on every cycle:
- the PC holds unless a load is enabled;
- the instruction register holds without its load;
- a zero rs field gives a zero A latch;
- a PC+4 fetch steps by exactly four;
- a jump forms its address from the old PC and target;
- a subtract of A and B flags zero exactly when they are equal.

The remaining behaviour shows only through the bench's instruction sequences:
- the ALU results for each operation;
- sign extension of load offsets;
- the write-back path from memory and from the result latch;
- taken and untaken branch targets;
- the store address and data at the memory port.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_LATCH = 2'd0,
    OPB_STEP  = 2'd1,
    OPB_IMM   = 2'd2,
    OPB_IMMSH = 2'd3
  } opb_sel_e;

  typedef enum logic [1:0] {
    NPC_ALU    = 2'd0,
    NPC_RESULT = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/mdp_regfile.sv
module mdp_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] store [DEPTH];

  // entry 0 is never written; reads of index 0 are forced to zero
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store[raddr_b];
endmodule

// File: rtl/mdp_alu.sv
module mdp_alu
  import mdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [2:0]    op,
  output logic [DW-1:0] res,
  output logic          is_zero
);
  always_comb begin
    case (alu_op_e'(op))
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_SLT: res = {{(DW-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);
endmodule

// File: rtl/mdp_core.sv
module mdp_core
  import mdp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int RF_DEPTH = 8,
  parameter int OPW      = 4,
  parameter int IMMW     = 6,
  parameter int TGTW     = 12,
  parameter int STEP     = 4,
  parameter int SHIFT    = 2
) (
  input  logic           clk,
  input  logic           rst,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  input  logic           ctl_mem_rd,
  input  logic           ctl_mem_wr,
  input  logic           ctl_addr_sel,
  input  logic           ctl_ir_load,
  input  logic           ctl_pc_load,
  input  logic           ctl_pc_cond,
  input  logic [1:0]     ctl_pc_src,
  input  logic           ctl_srca,
  input  logic [1:0]     ctl_srcb,
  input  logic [2:0]     ctl_alu_op,
  input  logic           ctl_rf_we,
  input  logic           ctl_rf_dst,
  input  logic           ctl_rf_from_mem,
  output logic [OPW-1:0] opcode,
  output logic           zero
);
  localparam int RA     = $clog2(RF_DEPTH);
  localparam int RS_LSB = DW - OPW - RA;
  localparam int RT_LSB = RS_LSB - RA;
  localparam int RD_LSB = RT_LSB - RA;
  localparam int PCHI   = DW - TGTW - SHIFT;

  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [DW-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, pc_next, imm_sx, jaddr;
  logic [RA-1:0] f_rs, f_rt, f_rd, rf_waddr;
  logic          pc_en;

  assign f_rs = ir_q[RS_LSB +: RA];
  assign f_rt = ir_q[RT_LSB +: RA];
  assign f_rd = ir_q[RD_LSB +: RA];
  assign imm_sx = {{(DW-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign jaddr  = {pc_q[DW-1 -: PCHI], ir_q[TGTW-1:0], {SHIFT{1'b0}}};

  // operand steering
  assign alu_a = ctl_srca ? a_q : pc_q;
  always_comb begin
    case (opb_sel_e'(ctl_srcb))
      OPB_LATCH: alu_b = b_q;
      OPB_STEP:  alu_b = DW'(STEP);
      OPB_IMM:   alu_b = imm_sx;
      default:   alu_b = imm_sx << SHIFT;
    endcase
  end

  mdp_alu #(.DW(DW)) u_alu (
    .opa(alu_a), .opb(alu_b), .op(ctl_alu_op), .res(alu_y), .is_zero(zero)
  );

  // next program counter
  always_comb begin
    case (npc_sel_e'(ctl_pc_src))
      NPC_ALU:    pc_next = alu_y;
      NPC_RESULT: pc_next = res_q;
      NPC_JUMP:   pc_next = jaddr;
      default:    pc_next = pc_q;
    endcase
  end
  assign pc_en = ctl_pc_load | (ctl_pc_cond & zero);

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (pc_en) pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ctl_ir_load) ir_q <= mem_rdata;
  end

  // free-running holding registers
  always_ff @(posedge clk) begin
    mdr_q <= mem_rdata;
    a_q   <= rf_a;
    b_q   <= rf_b;
    res_q <= alu_y;
  end

  assign rf_waddr = ctl_rf_dst ? f_rd : f_rt;

  mdp_regfile #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
    .clk(clk),
    .we(ctl_rf_we),
    .waddr(rf_waddr),
    .wdata(ctl_rf_from_mem ? mdr_q : res_q),
    .raddr_a(f_rs),
    .raddr_b(f_rt),
    .rdata_a(rf_a),
    .rdata_b(rf_b)
  );

  assign mem_addr  = ctl_addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = ctl_mem_rd;
  assign mem_wr    = ctl_mem_wr;
  assign opcode    = ir_q[DW-1 -: OPW];
endmodule

// File: rtl/mdp_core_chk.sv
module mdp_core_chk #(
  parameter int DW     = 16,
  parameter int RA     = 3,
  parameter int RS_LSB = 9,
  parameter int TGTW   = 12,
  parameter int STEP   = 4,
  parameter int SHIFT  = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_pc_load,
  input logic          ctl_pc_cond,
  input logic [1:0]    ctl_pc_src,
  input logic          ctl_srca,
  input logic [1:0]    ctl_srcb,
  input logic [2:0]    ctl_alu_op,
  input logic          ctl_ir_load,
  input logic          zero,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] b_q
);
  localparam int PCHI = DW - TGTW - SHIFT;

  assert_pc_cleared_R1: assert property (@(posedge clk) rst |=> (pc_q == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_pc_load && ctl_pc_src == 2'd0 && !ctl_srca && ctl_srcb == 2'd1 && ctl_alu_op == 3'd0)
    |=> (pc_q == $past(pc_q) + DW'(STEP)));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl_ir_load |=> $stable(ir_q));

  assert_sub_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_alu_op == 3'd1 && ctl_srca && ctl_srcb == 2'd0) |-> (zero == (a_q == b_q)));

  assert_r0_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (ir_q[RS_LSB +: RA] == '0) |=> (a_q == '0));

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctl_pc_load && !(ctl_pc_cond && zero)) |=> $stable(pc_q));

  assert_jump_addr_R11: assert property (@(posedge clk) disable iff (rst)
    (ctl_pc_load && ctl_pc_src == 2'd2)
    |=> (pc_q == {$past(pc_q[DW-1 -: PCHI]), $past(ir_q[TGTW-1:0]), {SHIFT{1'b0}}}));
endmodule

bind mdp_core mdp_core_chk #(
  .DW(DW), .RA(RA), .RS_LSB(RS_LSB), .TGTW(TGTW), .STEP(STEP), .SHIFT(SHIFT)
) u_chk (
  .clk(clk), .rst(rst),
  .ctl_pc_load(ctl_pc_load), .ctl_pc_cond(ctl_pc_cond), .ctl_pc_src(ctl_pc_src),
  .ctl_srca(ctl_srca), .ctl_srcb(ctl_srcb), .ctl_alu_op(ctl_alu_op),
  .ctl_ir_load(ctl_ir_load), .zero(zero),
  .pc_q(pc_q), .ir_q(ir_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/mdp_core_test.sv
module mdp_core_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OP_R = 4'd0, OP_LW = 4'd1, OP_SW = 4'd2, OP_BEQ = 4'd3, OP_J = 4'd4;
  // {alu op, operand a, operand b, expected}
  localparam logic [50:0] VEC [7] = '{
    {3'd0, 16'h1234, 16'h0FF0, 16'h2224},
    {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
    {3'd2, 16'hF0F0, 16'h3C3C, 16'h3030},
    {3'd3, 16'hF000, 16'h000F, 16'hF00F},
    {3'd4, 16'hFFFF, 16'h0001, 16'h0001},
    {3'd4, 16'h0001, 16'hFFFF, 16'h0000},
    {3'd0, 16'h8000, 16'h8000, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_rd, mem_wr;
  logic ctl_mem_rd, ctl_mem_wr, ctl_addr_sel, ctl_ir_load, ctl_pc_load, ctl_pc_cond;
  logic [1:0] ctl_pc_src, ctl_srcb;
  logic ctl_srca, ctl_rf_we, ctl_rf_dst, ctl_rf_from_mem;
  logic [2:0] ctl_alu_op;
  logic [3:0] opcode;
  logic zero;

  logic [15:0] tmem [256];
  logic [15:0] exp_pc;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = tmem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) tmem[mem_addr[9:2]] <= mem_wdata;

  mdp_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ctl_mem_rd(ctl_mem_rd), .ctl_mem_wr(ctl_mem_wr),
    .ctl_addr_sel(ctl_addr_sel), .ctl_ir_load(ctl_ir_load), .ctl_pc_load(ctl_pc_load),
    .ctl_pc_cond(ctl_pc_cond), .ctl_pc_src(ctl_pc_src), .ctl_srca(ctl_srca), .ctl_srcb(ctl_srcb),
    .ctl_alu_op(ctl_alu_op), .ctl_rf_we(ctl_rf_we), .ctl_rf_dst(ctl_rf_dst),
    .ctl_rf_from_mem(ctl_rf_from_mem), .opcode(opcode), .zero(zero)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    ctl_mem_rd = 0; ctl_mem_wr = 0; ctl_addr_sel = 0; ctl_ir_load = 0; ctl_pc_load = 0;
    ctl_pc_cond = 0; ctl_pc_src = 0; ctl_srca = 0; ctl_srcb = 0; ctl_alu_op = 0;
    ctl_rf_we = 0; ctl_rf_dst = 0; ctl_rf_from_mem = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // fetch: PC+4 through the ALU (R2, R12) and instruction register load (R3)
  task automatic fetch(input logic [15:0] instr);
    tmem[exp_pc[9:2]] = instr;
    clr(); ctl_mem_rd = 1; ctl_ir_load = 1; ctl_srcb = 2'd1; ctl_pc_load = 1;
    #1 check("R2 fetch address", mem_addr, exp_pc);
    tick();
    exp_pc = exp_pc + 16'd4;
    check("R3 opcode", {12'd0, opcode}, {12'd0, instr[15:12]});
  endtask

  task automatic decode();
    clr(); ctl_srcb = 2'd3; tick();
  endtask

  task automatic rop(input logic [2:0] op, input logic [2:0] rd, input logic [2:0] rs, input logic [2:0] rt);
    fetch({OP_R, rs, rt, rd, 3'd0}); decode();
    clr(); ctl_srca = 1; ctl_alu_op = op; tick();
    clr(); ctl_rf_we = 1; ctl_rf_dst = 1; tick();
  endtask

  task automatic lw(input logic [2:0] rt, input logic [2:0] rs, input logic [5:0] off);
    fetch({OP_LW, rs, rt, off}); decode();
    clr(); ctl_srca = 1; ctl_srcb = 2'd2; tick();
    clr(); ctl_addr_sel = 1; ctl_mem_rd = 1; tick();
    clr(); ctl_rf_we = 1; ctl_rf_from_mem = 1; tick();
  endtask

  task automatic sw(input logic [2:0] rt, input logic [5:0] off, input logic [15:0] expv, input string tag);
    fetch({OP_SW, 3'd0, rt, off}); decode();
    clr(); ctl_srca = 1; ctl_srcb = 2'd2; tick();
    clr(); ctl_addr_sel = 1; ctl_mem_wr = 1;
    #1 check("R6 store address", mem_addr, {{10{off[5]}}, off});
    check({tag, " store data"}, mem_wdata, expv);
    check("R7 write strobe", {15'd0, mem_wr}, 16'd1);
    tick();
    check({tag, " memory word"}, tmem[off[5:0] >> 2 | 8'hF0], expv);
  endtask

  task automatic beq(input logic [2:0] rs, input logic [2:0] rt, input logic [5:0] off, input logic taken);
    logic [15:0] tgt;
    fetch({OP_BEQ, rs, rt, off}); decode();
    tgt = exp_pc + ({{10{off[5]}}, off} << 2);
    clr(); ctl_srca = 1; ctl_alu_op = 3'd1; ctl_pc_cond = 1; ctl_pc_src = 2'd1;
    #1 check("R5 zero flag", {15'd0, zero}, {15'd0, taken});
    tick();
    if (taken) exp_pc = tgt;
  endtask

  task automatic jmp(input logic [11:0] tgt);
    fetch({OP_J, tgt}); decode();
    clr(); ctl_pc_load = 1; ctl_pc_src = 2'd2; tick();
    exp_pc = {exp_pc[15:14], tgt, 2'b00};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 16'h0000;
    clr();
    exp_pc = 16'h0000;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1 check("R1 address after reset", mem_addr, 16'h0000);

    // ALU vectors via load, operate, store (R4, R6, R7, R8, R12); memory at -4, -8, -12
    for (int i = 0; i < 7; i++) begin
      tmem[255] = VEC[i][47:32];
      tmem[254] = VEC[i][31:16];
      lw(3'd1, 3'd0, 6'b111100);
      lw(3'd2, 3'd0, 6'b111000);
      rop(VEC[i][50:48], 3'd3, 3'd1, 3'd2);
      sw(3'd3, 6'b110100, VEC[i][15:0], "R4 R8 alu result");
    end

    // R9: write to register 0 is ignored, register 0 reads zero
    tmem[255] = 16'h00AA; tmem[254] = 16'h0055;
    lw(3'd1, 3'd0, 6'b111100);
    lw(3'd2, 3'd0, 6'b111000);
    rop(3'd3, 3'd0, 3'd1, 3'd2);
    sw(3'd0, 6'b110100, 16'h0000, "R9 register zero");
    // R6 load into rt from memory observed through a store
    sw(3'd1, 6'b110100, 16'h00AA, "R6 loaded value");

    // R10: branch not taken, then taken (forward by 2 words)
    beq(3'd1, 3'd2, 6'd2, 1'b0);
    fetch({OP_R, 12'd0});
    decode();
    beq(3'd1, 3'd1, 6'd2, 1'b1);
    fetch({OP_R, 12'd0});
    decode();

    // R11: jump
    jmp(12'h040);
    fetch({OP_R, 12'd0});
    decode();

    // R3: instruction register holds without its load
    tmem[252] = 16'hF000;
    lw(3'd4, 3'd0, 6'b110000);
    clr(); ctl_srca = 1; ctl_srcb = 2'd2; tick();
    clr(); ctl_addr_sel = 1; ctl_mem_rd = 1; tick();
    check("R3 opcode held without load", {12'd0, opcode}, {12'd0, OP_LW});

    // R1: reset mid-run clears the PC
    clr(); rst = 1; tick(); rst = 0;
    exp_pc = 16'h0000;
    #1 check("R1 address after second reset", mem_addr, 16'h0000);
    fetch({OP_R, 12'd0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule